// File: doc/BRIEF.md
# Millisecond Real-Time Clock with Periodic Interrupt

This peripheral keeps a free-running count of elapsed milliseconds. A prescaler divides the system clock down to a one-millisecond tick. Each tick advances an 18-bit counter. A processor talks to the block through a single command strobe carrying a two-bit operation code. One code returns the current count. Another code zeroes the count and restarts the millisecond phase, and it may be issued at any time.

The block also raises an interrupt request. A period-select input chooses the rate: once every 32 milliseconds, or once a minute. Counter overflow requests an interrupt in either mode. The request is latched until the processor acknowledges it. An enable input decides whether new events may set it.

Top module: `msclk_top`

## Requirements
- R1: While no clear is issued, the millisecond count increases by exactly one every CYC_PER_MS system clock cycles and is otherwise unchanged.
- R2: A read command (cmd_valid high with cmd_op = 2'b01) makes rd_valid high on the following cycle, with rd_data holding the count as it stood in the command cycle. If a tick lands in that same cycle, the value before the increment is returned.
- R3: A clear command (cmd_op = 2'b10) zeroes both the count and the prescaler phase. The first increment after it comes CYC_PER_MS cycles after the clock edge that took the command.
- R4: With period_sel = 0 (32 ms mode), the interrupt flag is set on the tick where the low five count bits roll over from 31 to 0. The first such event is 32 ms after a clear.
- R5: With period_sel = 1 (minute mode), the flag is set once every MIN_MS ticks. These ticks are counted by a divider that is separate from the counter and restarts on clear. Rollovers of the low five bits do not set the flag in this mode.
- R6: When the CNT_W-bit count passes its maximum, it wraps to zero and sets the flag, whatever the period select.
- R7: Once set, irq stays high until irq_ack is asserted; it drops on the cycle after the acknowledge.
- R8: While irq_en is low, none of the events set the flag.
- R9: A clear command also drops irq on the following cycle.
- R10: After reset, irq and rd_valid are low and the count reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Operation: 00 none, 01 read, 10 clear, 11 none |
| period_sel | input | 1 | Interrupt period: 0 = 32 ms, 1 = one minute |
| irq_en | input | 1 | Allows events to set the interrupt flag |
| irq_ack | input | 1 | Clears the interrupt flag |
| rd_valid | output | 1 | Read data valid, one cycle after a read command |
| rd_data | output | CNT_W | Millisecond count captured by the read |
| irq | output | 1 | Latched interrupt request |

## Verification
A prescaler that is off by one shows up as a read value that changes one cycle early or late at the millisecond boundary. It also shifts the first interrupt by a full 32 or 60000 cycles of error per period. A stale prescaler phase left over after a clear shows up within a single millisecond, as a read taken just before the boundary. A wrong flag state can be seen in three ways: irq stays high after an acknowledge or a clear, it rises in the wrong mode, or it stays low through the tick on which it should set.

// File: rtl/msclk_pkg.sv
package msclk_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_READ  = 2'b01,
        OP_CLEAR = 2'b10,
        OP_RSVD  = 2'b11
    } msclk_op_e;

    typedef enum logic {
        PER_32MS   = 1'b0,
        PER_MINUTE = 1'b1
    } msclk_period_e;

    // Events produced in one cycle by the time base
    typedef struct packed {
        logic ovf;
        logic wrap32;
        logic minute;
    } msclk_evt_t;

    localparam int unsigned WRAP_BITS = 5;

    function automatic logic evt_hit(msclk_evt_t e, msclk_period_e sel);
        return e.ovf | ((sel == PER_MINUTE) ? e.minute : e.wrap32);
    endfunction

endpackage

// File: rtl/msclk_prescaler.sv
module msclk_prescaler #(
    parameter int unsigned CYC_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int unsigned PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYC_PER_MS - 1);

    logic [PW-1:0] phase_q;

    assign tick = (phase_q == LAST) && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/msclk_counter.sv
module msclk_counter
    import msclk_pkg::*;
#(
    parameter int unsigned CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             wrap32
);
    logic [CNT_W-1:0] count_q;

    assign count  = count_q;
    assign ovf    = tick && (count_q == {CNT_W{1'b1}});
    assign wrap32 = tick && (count_q[WRAP_BITS-1:0] == {WRAP_BITS{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/msclk_minute_div.sv
module msclk_minute_div #(
    parameter int unsigned MIN_MS = 60000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic pulse
);
    localparam int unsigned MW = (MIN_MS > 1) ? $clog2(MIN_MS) : 1;
    localparam logic [MW-1:0] LAST = MW'(MIN_MS - 1);

    logic [MW-1:0] ms_q;

    assign pulse = tick && (ms_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ms_q <= '0;
        end else if (tick) begin
            ms_q <= (ms_q == LAST) ? '0 : ms_q + 1'b1;
        end
    end
endmodule

// File: rtl/msclk_irq.sv
module msclk_irq
    import msclk_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic          ack,
    input  msclk_period_e sel,
    input  msclk_evt_t    evt,
    output logic          flag
);
    logic flag_q;
    logic set_now;

    assign set_now = en && evt_hit(evt, sel);
    assign flag    = flag_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flag_q <= 1'b0;
        end else if (set_now) begin
            flag_q <= 1'b1;
        end else if (ack) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/msclk_top.sv
module msclk_top
    import msclk_pkg::*;
#(
    parameter int unsigned CYC_PER_MS = 100000,
    parameter int unsigned CNT_W      = 18,
    parameter int unsigned MIN_MS     = 60000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             period_sel,
    input  logic             irq_en,
    input  logic             irq_ack,
    output logic             rd_valid,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    msclk_op_e        op;
    msclk_period_e    per;
    msclk_evt_t       evt;
    logic             do_clr;
    logic             do_rd;
    logic             tick;
    logic             minute;
    logic             ovf;
    logic             wrap32;
    logic [CNT_W-1:0] count_q;
    logic             rd_valid_q;
    logic [CNT_W-1:0] rd_data_q;

    assign op     = msclk_op_e'(cmd_op);
    assign per    = msclk_period_e'(period_sel);
    assign do_clr = cmd_valid && (op == OP_CLEAR);
    assign do_rd  = cmd_valid && (op == OP_READ);

    msclk_prescaler #(.CYC_PER_MS(CYC_PER_MS)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (do_clr),
        .tick (tick)
    );

    msclk_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (do_clr),
        .tick   (tick),
        .count  (count_q),
        .ovf    (ovf),
        .wrap32 (wrap32)
    );

    msclk_minute_div #(.MIN_MS(MIN_MS)) u_min (
        .clk   (clk),
        .rst   (rst),
        .clr   (do_clr),
        .tick  (tick),
        .pulse (minute)
    );

    assign evt = '{ovf: ovf, wrap32: wrap32, minute: minute};

    msclk_irq u_irq (
        .clk  (clk),
        .rst  (rst),
        .clr  (do_clr),
        .en   (irq_en),
        .ack  (irq_ack),
        .sel  (per),
        .evt  (evt),
        .flag (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= do_rd;
            if (do_rd) begin
                rd_data_q <= count_q;
            end
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
endmodule

// File: rtl/msclk_top_chk.sv
module msclk_top_chk #(
    parameter int unsigned CNT_W = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             do_clr,
    input logic             do_rd,
    input logic             tick,
    input logic             irq_ack,
    input logic [CNT_W-1:0] count_q,
    input logic             rd_valid,
    input logic [CNT_W-1:0] rd_data,
    input logic             irq
);
    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!do_clr && tick) |=> (count_q == $past(count_q) + 1'b1));

    p_count_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!do_clr && !tick) |=> $stable(count_q));

    p_read_value_r2: assert property (@(posedge clk) disable iff (rst)
        do_rd |=> (rd_valid && rd_data == $past(count_q)));

    p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
        do_clr |=> (count_q == '0));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack && !do_clr) |=> irq);

    p_clear_flag_r9: assert property (@(posedge clk) disable iff (rst)
        do_clr |=> !irq);
endmodule

bind msclk_top msclk_top_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .do_clr   (do_clr),
    .do_rd    (do_rd),
    .tick     (tick),
    .irq_ack  (irq_ack),
    .count_q  (count_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .irq      (irq)
);

// File: tb/msclk_top_tb.sv
module msclk_top_tb;
    localparam int CYC   = 4;
    localparam int CW    = 18;
    localparam int OW    = 7;
    localparam int NVEC  = 8;
    // {cycles waited after clear, expected count}
    localparam int VEC [NVEC][2] = '{
        '{0, 0}, '{3, 0}, '{4, 1}, '{7, 1},
        '{8, 2}, '{100, 25}, '{129, 32}, '{1001, 250}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic          period_sel = 1'b0;
    logic          irq_en = 1'b0;
    logic          irq_ack = 1'b0;
    logic          rd_valid, irq, o_rd_valid, o_irq;
    logic [CW-1:0] rd_data;
    logic [OW-1:0] o_rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    msclk_top #(.CYC_PER_MS(CYC), .CNT_W(CW), .MIN_MS(40)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .period_sel(period_sel), .irq_en(irq_en), .irq_ack(irq_ack),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
    );

    msclk_top #(.CYC_PER_MS(CYC), .CNT_W(OW), .MIN_MS(1000)) u_dut_ovf (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .period_sel(period_sel), .irq_en(irq_en), .irq_ack(irq_ack),
        .rd_valid(o_rd_valid), .rd_data(o_rd_data), .irq(o_irq)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic issue(logic [1:0] op);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 2'b00;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_irq();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        // R10: reset state
        check("R10 irq", int'(irq), 0);
        check("R10 rd_valid", int'(rd_valid), 0);
        issue(2'b01);
        check("R10 rd_valid after read", int'(rd_valid), 1);
        check("R10 count", int'(rd_data), 0);

        // R1 R2 R3: vector table, each entry clears then reads
        for (int i = 0; i < NVEC; i++) begin
            issue(2'b10);
            wait_n(VEC[i][0]);
            issue(2'b01);
            check($sformatf("R1/R3 read after %0d cycles", VEC[i][0]),
                  int'(rd_data), VEC[i][1]);
        end
        // R2: command code 11 performs no read
        issue(2'b11);
        check("R2 rd_valid on reserved code", int'(rd_valid), 0);

        // R4: 32 ms period
        irq_en = 1'b1; period_sel = 1'b0;
        issue(2'b10);
        wait_n(127);
        check("R4 before 32 ms", int'(irq), 0);
        wait_n(1);
        check("R4 at 32 ms", int'(irq), 1);
        // R7: sticky until acknowledged
        wait_n(10);
        check("R7 held", int'(irq), 1);
        ack_irq();
        check("R7 after ack", int'(irq), 0);

        // R5: minute mode (40 ms here), 32 ms rollover ignored
        period_sel = 1'b1;
        issue(2'b10);
        wait_n(159);
        check("R5 before period", int'(irq), 0);
        wait_n(1);
        check("R5 at period", int'(irq), 1);
        ack_irq();

        // R8: disabled events ignored
        irq_en = 1'b0; period_sel = 1'b0;
        issue(2'b10);
        wait_n(200);
        check("R8 disabled", int'(irq), 0);

        // R9: clear drops the flag
        irq_en = 1'b1;
        issue(2'b10);
        wait_n(128);
        check("R9 set first", int'(irq), 1);
        issue(2'b10);
        check("R9 after clear", int'(irq), 0);

        // R6: overflow of 7-bit instance (minute period far away)
        period_sel = 1'b1;
        issue(2'b10);
        wait_n(511);
        check("R6 before overflow", int'(o_irq), 0);
        wait_n(1);
        check("R6 at overflow", int'(o_irq), 1);
        ack_irq();
        issue(2'b10);
        wait_n(512);
        issue(2'b01);
        check("R6 wrapped count", int'(o_rd_data), 0);

        finish_run();
    end
endmodule